// File: doc/BRIEF.md
# Thermal Sprint Budget Controller

This controller runs short bursts in which many cores work well above the power level the package can dissipate. When software signals that parallel work is ready, it raises the clock to the high level. It then brings extra cores online one at a time, so the supply never sees one large current step. While the burst runs, it sums the activity counts of the enabled cores into a heat estimate and compares that estimate with a programmable thermal capacity.

As the estimate approaches the capacity, the controller asks the runtime to move threads back to one core. If the runtime acknowledges, the burst ends cleanly: one core stays on and the clock drops to the low level. If the runtime stays silent past a programmable timeout, the controller drops the clock to the low level on its own and keeps asking. After any burst, a cooldown period drains the heat estimate at a fixed rate. No new burst can start until that period has expired.

Top module: `sprint_governor`

## Requirements
- R1: While and after reset, before any stimulus, `state_o` is 0 (idle), `core_en` has only bit 0 set, `freq_hi` and `migrate_req` are 0, and `heat_o` is 0.
- R2: From idle, the state moves to 1 (ramp) on the next edge only if `work_avail` is high. While `work_avail` is low, the block stays idle. In states 1, 2 and 3 `freq_hi` is 1.
- R3: In ramp, `core_en` is a thermometer code starting at bit 0. One more core is enabled every max(`cfg_step`,1) cycles. The edge that enables the last core also moves the state to 2 (sprint).
- R4: In states 1 to 4, each edge adds to `heat_o` the sum of the activity lanes of the enabled cores. Lane i is `act_cnt[i*ACTW +: ACTW]`. In idle, `heat_o` holds its value.
- R5: The heat sum saturates at all ones and never wraps.
- R6: In ramp or sprint, when `heat_o` is at least `cfg_budget - cfg_margin` (0 if the margin exceeds the budget), the next edge enters state 3 (warn). In warn, `migrate_req` is 1 and the cores and clock level are kept.
- R7: `rt_ack` high in warn moves the block to state 5 (cooldown) on the next edge, without passing through throttle.
- R8: After max(`cfg_timeout`,1) cycles in warn without `rt_ack`, the state becomes 4 (throttle). Throttle has `freq_hi` 0, keeps the cores enabled and keeps `migrate_req` at 1, until `rt_ack` moves the block to cooldown.
- R9: In cooldown, only core 0 is enabled and `freq_hi` is 0. `heat_o` decreases by `cfg_drain` per cycle and stops at 0. The block stays max(`cfg_cool`,1) cycles and then returns to idle. `work_avail` has no effect in cooldown.
- R10: `work_avail` going low in ramp or sprint moves the block to cooldown on the next edge. This takes priority over entering warn.
- R11: `over_budget` is 1 exactly when `heat_o` is at least `cfg_budget`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| work_avail | input | 1 | Parallel work is ready |
| act_cnt | input | NCORES*ACTW | Per-core activity counts for this cycle |
| rt_ack | input | 1 | Runtime acknowledges migration |
| cfg_budget | input | EW | Thermal capacity |
| cfg_margin | input | EW | Early-warning margin below capacity |
| cfg_drain | input | EW | Heat removed per cooldown cycle |
| cfg_step | input | CW | Cycles between core enables |
| cfg_timeout | input | CW | Warn cycles before hardware throttle |
| cfg_cool | input | CW | Cooldown length in cycles |
| core_en | output | NCORES | Core enables |
| freq_hi | output | 1 | High clock level selected |
| migrate_req | output | 1 | Request to move threads to one core |
| state_o | output | 3 | Current state code |
| over_budget | output | 1 | Heat at or above capacity |
| heat_o | output | EW | Heat estimate |

## Verification
The hardest case to reach is saturation. It needs a heat sum that hits all ones before the warning threshold is crossed, and then it must stay pinned there while warn lasts. The stimulus sets the capacity to all ones with no margin, drives every lane at its maximum for about a thousand cycles, and holds warn for many cycles afterwards. The throttle path is reached by sweeping the timeout and withholding the acknowledge. Each run is followed by cycle-exact comparison of state, enables and heat.

// File: rtl/sprint_governor.sv
module sprint_governor #(
  parameter int NCORES = 16,
  parameter int ACTW   = 8,
  parameter int EW     = 32,
  parameter int CW     = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    work_avail,
  input  logic [NCORES*ACTW-1:0]  act_cnt,
  input  logic                    rt_ack,
  input  logic [EW-1:0]           cfg_budget,
  input  logic [EW-1:0]           cfg_margin,
  input  logic [EW-1:0]           cfg_drain,
  input  logic [CW-1:0]           cfg_step,
  input  logic [CW-1:0]           cfg_timeout,
  input  logic [CW-1:0]           cfg_cool,
  output logic [NCORES-1:0]       core_en,
  output logic                    freq_hi,
  output logic                    migrate_req,
  output logic [2:0]              state_o,
  output logic                    over_budget,
  output logic [EW-1:0]           heat_o
);
  localparam int NW = $clog2(NCORES + 1);
  localparam int SW = ACTW + NW;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_RAMP = 3'd1, S_SPRINT = 3'd2,
    S_WARN = 3'd3, S_THROT = 3'd4, S_COOL = 3'd5
  } st_t;

  st_t           st;
  logic [NW-1:0] ncores;
  logic [CW-1:0] tmr;
  logic [EW-1:0] heat;
  logic [SW-1:0] inc;
  logic [EW:0]   sum_ext;
  logic [EW-1:0] thresh;
  logic [CW:0]   tmr_nx;
  logic          near, hit_step, hit_tmo, hit_cool;

  for (genvar g = 0; g < NCORES; g++) begin : g_en
    assign core_en[g] = (32'(ncores) > g);
  end

  always_comb begin
    inc = '0;
    for (int i = 0; i < NCORES; i++)
      if (core_en[i]) inc = inc + SW'(act_cnt[i*ACTW +: ACTW]);
  end

  assign sum_ext  = {1'b0, heat} + (EW+1)'(inc);
  assign thresh   = (cfg_margin > cfg_budget) ? '0 : cfg_budget - cfg_margin;
  assign near     = heat >= thresh;
  assign tmr_nx   = {1'b0, tmr} + (CW+1)'(1);
  assign hit_step = tmr_nx >= {1'b0, cfg_step};
  assign hit_tmo  = tmr_nx >= {1'b0, cfg_timeout};
  assign hit_cool = tmr_nx >= {1'b0, cfg_cool};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ncores <= NW'(1);
      tmr    <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (work_avail) begin
          st  <= S_RAMP;
          tmr <= '0;
        end
        S_RAMP, S_SPRINT: begin
          if (!work_avail) begin
            st     <= S_COOL;
            tmr    <= '0;
            ncores <= NW'(1);
          end else if (near) begin
            st  <= S_WARN;
            tmr <= '0;
          end else if (st == S_RAMP) begin
            if (hit_step) begin
              tmr    <= '0;
              ncores <= ncores + NW'(1);
              if (ncores == NW'(NCORES - 1)) st <= S_SPRINT;
            end else begin
              tmr <= tmr_nx[CW-1:0];
            end
          end
        end
        S_WARN: begin
          if (rt_ack) begin
            st     <= S_COOL;
            tmr    <= '0;
            ncores <= NW'(1);
          end else if (hit_tmo) begin
            st  <= S_THROT;
            tmr <= '0;
          end else begin
            tmr <= tmr_nx[CW-1:0];
          end
        end
        S_THROT: if (rt_ack) begin
          st     <= S_COOL;
          tmr    <= '0;
          ncores <= NW'(1);
        end
        S_COOL: begin
          if (hit_cool) begin
            st  <= S_IDLE;
            tmr <= '0;
          end else begin
            tmr <= tmr_nx[CW-1:0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      heat <= '0;
    else if (st == S_RAMP || st == S_SPRINT || st == S_WARN || st == S_THROT)
      heat <= sum_ext[EW] ? '1 : sum_ext[EW-1:0];
    else if (st == S_COOL)
      heat <= (heat > cfg_drain) ? heat - cfg_drain : '0;
  end

  assign freq_hi     = (st == S_RAMP) || (st == S_SPRINT) || (st == S_WARN);
  assign migrate_req = (st == S_WARN) || (st == S_THROT);
  assign state_o     = st;
  assign over_budget = heat >= cfg_budget;
  assign heat_o      = heat;
endmodule

// File: rtl/sprint_governor_chk.sv
module sprint_governor_chk #(
  parameter int NCORES = 16,
  parameter int EW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              work_avail,
  input logic              rt_ack,
  input logic [NCORES-1:0] core_en,
  input logic              freq_hi,
  input logic              migrate_req,
  input logic [2:0]        state_o,
  input logic [EW-1:0]     heat_o
);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && !work_avail) |=> state_o == 3'd0);

  a_r3_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    core_en[0] && (((core_en + NCORES'(1)) & core_en) == '0));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o >= 3'd1 && state_o <= 3'd4) |=> heat_o >= $past(heat_o));

  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd5 |=> heat_o <= $past(heat_o));

  a_r9_single_core: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd5 |-> (core_en == NCORES'(1) && !freq_hi));

  a_r7_ack_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && rt_ack) |=> state_o == 3'd5);

  a_r8_throttle_low: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd4 |-> (!freq_hi && migrate_req));

  a_r6_migrate_state: assert property (@(posedge clk) disable iff (!rst_n)
    migrate_req |-> (state_o == 3'd3 || state_o == 3'd4));
endmodule

bind sprint_governor sprint_governor_chk #(.NCORES(NCORES), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .work_avail(work_avail), .rt_ack(rt_ack),
  .core_en(core_en), .freq_hi(freq_hi), .migrate_req(migrate_req),
  .state_o(state_o), .heat_o(heat_o)
);

// File: tb/sprint_governor_tb.sv
module sprint_governor_tb;
  localparam int NC = 4, AW = 4, EW = 16, CW = 8;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, work = 1'b0, ack = 1'b0;
  logic [NC*AW-1:0] act = '0;
  logic [EW-1:0] budget = '1, margin = '0, drain = '0;
  logic [CW-1:0] stp = 8'd1, tmo = 8'd1, cool = 8'd1;
  logic [NC-1:0] core_en;
  logic freq_hi, migrate_req, over_budget;
  logic [2:0] state_o;
  logic [EW-1:0] heat_o;

  int vecs = 0, errs = 0;
  bit done = 0;
  string tag = "R1";
  int m_st = 0, m_nc = 1, m_tmr = 0, m_e = 0;

  always #2 clk = ~clk;

  sprint_governor #(.NCORES(NC), .ACTW(AW), .EW(EW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .work_avail(work), .act_cnt(act), .rt_ack(ack),
    .cfg_budget(budget), .cfg_margin(margin), .cfg_drain(drain),
    .cfg_step(stp), .cfg_timeout(tmo), .cfg_cool(cool),
    .core_en(core_en), .freq_hi(freq_hi), .migrate_req(migrate_req),
    .state_o(state_o), .over_budget(over_budget), .heat_o(heat_o));

  function automatic int lane(int i);
    return int'(act[i*AW +: AW]);
  endfunction

  task automatic set_act(int base);
    for (int i = 0; i < NC; i++) act[i*AW +: AW] = AW'((base + 3*i) % (1 << AW));
  endtask

  task automatic cmp(string what, string req, int a, int e);
    if (a != e) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  task automatic chk();
    vecs++;
    cmp("state", tag, int'(state_o), m_st);
    cmp("core_en", tag, int'(core_en), (1 << m_nc) - 1);
    cmp("freq_hi", tag, int'(freq_hi), (m_st >= 1 && m_st <= 3) ? 1 : 0);
    cmp("migrate_req", tag, int'(migrate_req), (m_st == 3 || m_st == 4) ? 1 : 0);
    cmp("heat", tag, int'(heat_o), m_e);
    cmp("over_budget", "R11", int'(over_budget), (m_e >= int'(budget)) ? 1 : 0);
  endtask

  task automatic step();
    int nst = m_st, nnc = m_nc, ntm = m_tmr, ne = m_e, inc = 0, thr;
    for (int i = 0; i < m_nc; i++) inc += lane(i);
    thr = (margin > budget) ? 0 : int'(budget) - int'(margin);
    case (m_st)
      0: if (work) begin nst = 1; ntm = 0; end
      1, 2: begin
        if (!work) begin nst = 5; ntm = 0; nnc = 1; end
        else if (m_e >= thr) begin nst = 3; ntm = 0; end
        else if (m_st == 1) begin
          if (m_tmr + 1 >= int'(stp)) begin
            ntm = 0; nnc = m_nc + 1;
            if (nnc == NC) nst = 2;
          end else ntm = m_tmr + 1;
        end
      end
      3: begin
        if (ack) begin nst = 5; ntm = 0; nnc = 1; end
        else if (m_tmr + 1 >= int'(tmo)) begin nst = 4; ntm = 0; end
        else ntm = m_tmr + 1;
      end
      4: if (ack) begin nst = 5; ntm = 0; nnc = 1; end
      5: begin
        if (m_tmr + 1 >= int'(cool)) begin nst = 0; ntm = 0; end
        else ntm = m_tmr + 1;
      end
      default: ;
    endcase
    if (m_st >= 1 && m_st <= 4) ne = (m_e + inc > EMAX) ? EMAX : m_e + inc;
    else if (m_st == 5) ne = (m_e > int'(drain)) ? m_e - int'(drain) : 0;
    @(posedge clk);
    m_st = nst; m_nc = nnc; m_tmr = ntm; m_e = ne;
    @(negedge clk);
    chk();
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic run_until(int st, int lim);
    int k = 0;
    while (m_st != st && k < lim) begin step(); k++; end
    vecs++;
    if (m_st != st) begin
      errs++;
      $display("FAIL %s state never reached actual=%0d expected=%0d", tag, m_st, st);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    chk();
    rst_n = 1'b1;
    step();

    tag = "R2";
    set_act(3);
    run(8);

    for (int s = 1; s <= 3; s++) begin
      for (int b = 0; b <= 5; b += 5) begin
        tag = (b == 0) ? "R3" : "R4";
        stp = CW'(s); budget = '1; margin = '0; cool = 8'd3; drain = '1;
        set_act(b); work = 1'b1;
        run((NC - 1) * s + 4);
        tag = "R10";
        work = 1'b0;
        run(6);
      end
    end

    tag = "R6";
    budget = 16'd200; margin = 16'd50; stp = 8'd1; tmo = 8'd10;
    cool = 8'd60; drain = 16'd7; set_act(7); work = 1'b1;
    run_until(3, 500);
    run(3);
    tag = "R7";
    ack = 1'b1; step(); ack = 1'b0;
    run(2);
    tag = "R9";
    run_until(1, 200);
    work = 1'b0;
    run_until(0, 200);

    for (int t = 1; t <= 4; t++) begin
      tag = "R8";
      tmo = CW'(t); cool = 8'd5; drain = '1; set_act(2 + t); work = 1'b1;
      run_until(3, 500);
      run(t + 2);
      ack = 1'b1; step(); ack = 1'b0; work = 1'b0;
      run_until(0, 200);
    end

    tag = "R6";
    budget = 16'd10; margin = 16'd20; tmo = 8'd5; work = 1'b1;
    run(4);
    ack = 1'b1; step(); ack = 1'b0; work = 1'b0;
    run_until(0, 200);

    tag = "R5";
    budget = '1; margin = '0; tmo = 8'd200; stp = 8'd1; act = '1; work = 1'b1;
    run_until(3, 2000);
    run(60);
    ack = 1'b1; step(); ack = 1'b0; work = 1'b0;
    drain = '1; cool = 8'd4;
    run_until(0, 100);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule